// File: doc/BRIEF.md
# Frame Sync Alignment Monitor

This block produces a periodic frame-sync pulse from a fast output clock. It also watches how far that pulse has drifted from the currently selected input sync. The block aligns its frame to an input sync at three points: when it comes up, when PLL lock returns after a loss, and when a realignment is requested. Once aligned and while lock holds, it counts a fixed number of fast-clock cycles per frame. It never lets a later input sync pull the frame. This keeps the output frame length constant across input clock switches.

Every input sync that arrives while the frame runs is measured against the nearest output pulse. The result is a signed cycle offset. When the offset's magnitude exceeds a limit (two cycles by default), an alignment alarm is raised. A realignment clears the offset and the alarm. Losing lock silences both outputs until the block has realigned. The PLL and the phase build-out logic are outside this block.

Top module: `fsync_align_monitor`

## Requirements
- R1: After reset with `pll_locked` high, `fsync_out` stays low until the first `sync_in` pulse is sampled. That sample aligns the frame, and `fsync_out` is high in the cycle right after the sampling edge.
- R2: When `pll_locked` rises again after being low, `fsync_out` stays low until the next `sync_in` is sampled. That sample realigns the frame in the same way as R1.
- R3: While aligned and locked, with no realignment in effect, `fsync_out` is a one-cycle pulse every `FRAME_LEN` cycles, whenever `sync_in` arrives.
- R4: Let c be the frame position at which a `sync_in` is sampled while aligned. Position 0 is the cycle in which `fsync_out` is high. The offset is c+1 when c < `FRAME_LEN`/2, and c-(`FRAME_LEN`-1) otherwise. The in-phase position c = `FRAME_LEN`-1 gives an offset of 0.
- R5: `align_alarm` takes its new value in the cycle after each measured `sync_in`. It is high exactly when the magnitude of the latest offset is greater than `ALARM_LIMIT`. An offset of exactly ±`ALARM_LIMIT` leaves it low.
- R6: A one-cycle `realign_req` is held until the next `sync_in` and takes effect there. A request sampled together with a `sync_in` takes effect at that same `sync_in`. The request alone changes neither output. The realigning `sync_in` re-phases `fsync_out` as in R1 and clears `align_alarm`.
- R7: While `pll_locked` is low, `fsync_out` and `align_alarm` are low in that same cycle. `sync_in` and `realign_req` have no effect during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast output clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sync_in | input | 1 | One-cycle pulse from the currently selected input sync |
| pll_locked | input | 1 | PLL lock status, high when locked |
| realign_req | input | 1 | One-cycle realignment request |
| fsync_out | output | 1 | One-cycle output frame-sync pulse |
| align_alarm | output | 1 | High while the measured sync offset exceeds the limit |

## Verification
The bench builds the block with `FRAME_LEN` = 16 and `ALARM_LIMIT` = 2. With these values a full frame takes only sixteen cycles. That makes it quick to place an input sync at any chosen position and to confirm that the following output pulse has not moved. Both sides of the limit can be driven on each sign: offsets of -2 and +2 stay quiet, while -3 and +3 raise the alarm. The split between positions 7 and 8 lets one case probe the largest offsets, +8 and -7.

// File: rtl/fsam_pkg.sv
// Package: shared types for the frame sync alignment monitor.
// Assumes: nothing beyond IEEE 1800-2017.
package fsam_pkg;

    // Control states: waiting for lock, waiting for an aligning sync, running.
    typedef enum logic [1:0] {
        ST_UNLOCKED = 2'd0,
        ST_ALIGN    = 2'd1,
        ST_RUN      = 2'd2
    } fsam_state_e;

endpackage

// File: rtl/fsam_ctrl.sv
// Module: fsam_ctrl
// Decides when the frame is (re)aligned and when an input sync is only measured.
// It tracks lock, the start-up and relock alignment, and a held realign request.
// Assumes: sync_in and realign_req are single-cycle pulses in the clk domain.
module fsam_ctrl
    import fsam_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    input  logic pll_locked,
    input  logic realign_req,
    output logic run,
    output logic align,
    output logic measure,
    output logic clear
);

    fsam_state_e state_q, state_d;
    logic        pend_q;

    // Classify the current input sync as an aligning event or a measurement.
    always_comb begin
        align   = 1'b0;
        measure = 1'b0;
        if (pll_locked && sync_in) begin
            if (state_q == ST_ALIGN) begin
                align = 1'b1;
            end else if (state_q == ST_RUN) begin
                if (pend_q || realign_req) begin
                    align = 1'b1;
                end else begin
                    measure = 1'b1;
                end
            end
        end
    end

    // Clear the measured offset on realignment and for as long as lock is missing.
    always_comb begin
        clear = align || !pll_locked;
    end

    // Next-state choice for the lock and alignment sequence.
    always_comb begin
        state_d = state_q;
        if (!pll_locked) begin
            state_d = ST_UNLOCKED;
        end else begin
            unique case (state_q)
                ST_UNLOCKED: state_d = ST_ALIGN;
                ST_ALIGN:    if (align) state_d = ST_RUN;
                ST_RUN:      state_d = ST_RUN;
                default:     state_d = ST_UNLOCKED;
            endcase
        end
    end

    // State register; reset starts from the unlocked state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_UNLOCKED;
        end else begin
            state_q <= state_d;
        end
    end

    // Hold a realign request until an aligning sync uses it or lock drops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (!pll_locked || align) begin
            pend_q <= 1'b0;
        end else if (realign_req) begin
            pend_q <= 1'b1;
        end
    end

    // Frame counter runs only in the aligned state.
    always_comb begin
        run = (state_q == ST_RUN);
    end

    AST_ALIGN_ENTERS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        align |=> (state_q == ST_RUN)); // R1
    AST_RELOCK_NEEDS_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_locked) |=> (state_q != ST_RUN)); // R2
    AST_UNLOCK_DROPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        !pll_locked |=> (state_q == ST_UNLOCKED)); // R7

endmodule

// File: rtl/fsam_frame_counter.sv
// Module: fsam_frame_counter
// Counts fast-clock cycles within the output frame and marks position 0.
// Assumes: FRAME_LEN >= 4; align restarts the frame at position 0.
module fsam_frame_counter #(
    parameter int FRAME_LEN = 16,
    parameter int CNT_W     = $clog2(FRAME_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             align,
    output logic [CNT_W-1:0] pos,
    output logic             at_start
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_LEN - 1);

    logic [CNT_W-1:0] cnt_q;

    // Frame position: restart on align, wrap at the frame end, park at zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (align) begin
            cnt_q <= '0;
        end else if (run) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end else begin
            cnt_q <= '0;
        end
    end

    // Expose the position and the frame-start marker.
    always_comb begin
        pos      = cnt_q;
        at_start = (cnt_q == '0);
    end

    AST_FIXED_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run) && !$past(align) && (cnt_q == '0)) |-> ($past(cnt_q) == LAST)); // R3

endmodule

// File: rtl/fsam_phase_meter.sv
// Module: fsam_phase_meter
// Turns the frame position of a measured input sync into a signed offset to the
// nearest output pulse, and keeps the alarm for offsets beyond the limit.
// Assumes: measure and clear never need to act in the same cycle (clear wins).
module fsam_phase_meter #(
    parameter int FRAME_LEN   = 16,
    parameter int CNT_W       = $clog2(FRAME_LEN),
    parameter int ALARM_LIMIT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             measure,
    input  logic             clear,
    input  logic [CNT_W-1:0] pos,
    output logic             alarm
);

    localparam int ERR_W = CNT_W + 1;
    localparam int HALF  = FRAME_LEN / 2;
    localparam int LAST  = FRAME_LEN - 1;

    logic signed [ERR_W-1:0] err_q, err_d;
    logic                    alarm_q, alarm_d;

    // Signed offset: late inputs count up from +1, early inputs count down from 0.
    function automatic logic signed [ERR_W-1:0] pos_to_err(input logic [CNT_W-1:0] c);
        if (int'(c) < HALF) begin
            return ERR_W'(int'(c) + 1);
        end
        return ERR_W'(int'(c) - LAST);
    endfunction

    // New offset and alarm for the current measurement.
    always_comb begin
        err_d   = pos_to_err(pos);
        alarm_d = (int'(err_d) > ALARM_LIMIT) || (int'(err_d) < -ALARM_LIMIT);
    end

    // Offset and alarm registers: cleared on realign or unlock, updated per measurement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q   <= '0;
            alarm_q <= 1'b0;
        end else if (clear) begin
            err_q   <= '0;
            alarm_q <= 1'b0;
        end else if (measure) begin
            err_q   <= err_d;
            alarm_q <= alarm_d;
        end
    end

    // Drive the alarm output.
    always_comb begin
        alarm = alarm_q;
    end

    AST_CLEAR_DROPS_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!alarm_q && (err_q == '0))); // R6
    AST_IN_PHASE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (measure && !clear && (int'(pos) == LAST)) |=> (!alarm_q && (err_q == '0))); // R4
    AST_ERR_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(err_q) <= HALF) && (int'(err_q) > -HALF)); // R4

endmodule

// File: rtl/fsync_align_monitor.sv
// Module: fsync_align_monitor (top)
// Generates the output frame sync from the fast clock, aligns it to the active
// input sync at start-up, relock or on request, and flags accumulated drift.
// Assumes: all inputs are synchronous to clk; lock gates both outputs directly.
module fsync_align_monitor #(
    parameter int FRAME_LEN   = 16,
    parameter int ALARM_LIMIT = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    input  logic pll_locked,
    input  logic realign_req,
    output logic fsync_out,
    output logic align_alarm
);

    localparam int CNT_W = $clog2(FRAME_LEN);

    logic             run, align, measure, clear;
    logic [CNT_W-1:0] pos;
    logic             at_start;
    logic             alarm_raw;

    fsam_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_in    (sync_in),
        .pll_locked (pll_locked),
        .realign_req(realign_req),
        .run        (run),
        .align      (align),
        .measure    (measure),
        .clear      (clear)
    );

    fsam_frame_counter #(
        .FRAME_LEN(FRAME_LEN),
        .CNT_W    (CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .align   (align),
        .pos     (pos),
        .at_start(at_start)
    );

    fsam_phase_meter #(
        .FRAME_LEN  (FRAME_LEN),
        .CNT_W      (CNT_W),
        .ALARM_LIMIT(ALARM_LIMIT)
    ) u_meter (
        .clk    (clk),
        .rst_n  (rst_n),
        .measure(measure),
        .clear  (clear),
        .pos    (pos),
        .alarm  (alarm_raw)
    );

    // Outputs are gated by lock so that an unlock silences them in the same cycle.
    always_comb begin
        fsync_out   = run && at_start && pll_locked;
        align_alarm = alarm_raw && pll_locked;
    end

    AST_NO_ALARM_UNALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !align_alarm); // R7
    AST_SYNC_IGNORED_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!pll_locked && sync_in) |=> !run); // R7

endmodule

// File: tb/fsync_align_monitor_tb_top.sv
module fsync_align_monitor_tb_top;

    localparam int FL = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sync_in = 1'b0;
    logic pll_locked = 1'b1;
    logic realign_req = 1'b0;
    logic fsync_out, align_alarm;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    fsync_align_monitor #(.FRAME_LEN(FL), .ALARM_LIMIT(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .pll_locked(pll_locked),
        .realign_req(realign_req), .fsync_out(fsync_out), .align_alarm(align_alarm)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expect fsync_out low for n-1 negedges and high on the n-th.
    task automatic expect_fsync_in(input int n, input string req);
        int bad = 0;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            if ((i < n && fsync_out) || (i == n && !fsync_out)) bad = i;
        end
        chk(bad == 0, req, bad, 0);
    endtask

    // Expect fsync_out low for n negedges.
    task automatic expect_quiet(input int n, input string req);
        int hits = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (fsync_out) hits++;
        end
        chk(hits == 0, req, hits, 0);
    endtask

    task automatic pulse_sync();
        sync_in = 1'b1;
        @(negedge clk);
        sync_in = 1'b0;
    endtask

    // From frame position 0: sync at position k, check alarm and unchanged frame.
    task automatic probe(input int k, input logic exp_alarm, input string req);
        for (int i = 0; i < k; i++) @(negedge clk);
        pulse_sync();
        chk(align_alarm == exp_alarm, req, align_alarm, exp_alarm);
        if (k == FL - 1) chk(fsync_out == 1'b1, "R3", fsync_out, 1);
        else expect_fsync_in(FL - 1 - k, "R3");
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk(fsync_out == 1'b0, "R1 reset fsync", fsync_out, 0);
        chk(align_alarm == 1'b0, "R1 reset alarm", align_alarm, 0);
        rst_n = 1'b1;
    endtask

    task automatic t_startup();
        expect_quiet(20, "R1 no pulse before align");
        pulse_sync();
        chk(fsync_out == 1'b1, "R1 aligned pulse", fsync_out, 0 + 1);
        expect_fsync_in(FL, "R3 period");
        expect_fsync_in(FL, "R3 period");
    endtask

    task automatic t_drift();
        probe(15, 1'b0, "R4 in phase");
        probe(13, 1'b0, "R5 offset -2");
        probe(12, 1'b1, "R5 offset -3");
        probe(1, 1'b0, "R5 offset +2");
        probe(2, 1'b1, "R5 offset +3");
        probe(14, 1'b0, "R4 offset -1");
        probe(8, 1'b1, "R4 offset -7");
        probe(7, 1'b1, "R4 offset +8");
    endtask

    task automatic t_realign();
        repeat (2) @(negedge clk);
        realign_req = 1'b1;
        @(negedge clk);
        realign_req = 1'b0;
        chk(align_alarm == 1'b1, "R6 request alone", align_alarm, 1);
        expect_fsync_in(13, "R6 request keeps frame");
        repeat (5) @(negedge clk);
        pulse_sync();
        chk(fsync_out == 1'b1, "R6 realigned pulse", fsync_out, 1);
        chk(align_alarm == 1'b0, "R6 alarm cleared", align_alarm, 0);
        expect_fsync_in(FL, "R6 new period");
        probe(15, 1'b0, "R6 new phase");
        repeat (4) @(negedge clk);
        realign_req = 1'b1;
        pulse_sync();
        realign_req = 1'b0;
        chk(fsync_out == 1'b1, "R6 same-cycle request", fsync_out, 1);
        expect_fsync_in(FL, "R6 same-cycle period");
    endtask

    task automatic t_unlock();
        probe(3, 1'b1, "R5 offset +4");
        pll_locked = 1'b0;
        #1;
        chk(fsync_out == 1'b0, "R7 fsync gated", fsync_out, 0);
        chk(align_alarm == 1'b0, "R7 alarm gated", align_alarm, 0);
        @(negedge clk);
        pulse_sync();
        realign_req = 1'b1;
        @(negedge clk);
        realign_req = 1'b0;
        pulse_sync();
        expect_quiet(6, "R7 sync ignored");
        chk(align_alarm == 1'b0, "R7 alarm low", align_alarm, 0);
        pll_locked = 1'b1;
        expect_quiet(20, "R2 quiet after relock");
        chk(align_alarm == 1'b0, "R2 alarm after relock", align_alarm, 0);
        pulse_sync();
        chk(fsync_out == 1'b1, "R2 realigned pulse", fsync_out, 1);
        expect_fsync_in(FL, "R2 period");
        probe(15, 1'b0, "R2 phase");
    endtask

    initial begin
        t_reset();
        t_startup();
        t_drift();
        t_realign();
        t_unlock();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule